// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits on the command port of a graphics pipeline. It receives a stream of 32-bit words, reads the opcode from bits 31:24 of each header word, and groups the header with the parameter words that follow it into one packet. Fixed-size drawing commands get their length from a lookup by opcode. Line-strip commands have variable length and end on a marker word. Once a drawing packet is complete, the block gives a one-cycle strobe with the opcode, the word count and every word of the packet.

Environment commands do not produce a packet. Each one writes its whole word into one of eight shadow registers, and a 13-bit status word is rebuilt from two of them. Rectangle-transfer commands are also not sent downstream as packets. Their position and size words go to a separate memory-transfer engine as a strobe, with a flag that gives the transfer direction. Opcodes with no meaning are dropped as one-word no-ops. The block never stalls its input.

Top module: `gcf_framer`

## Requirements
- R1: A fixed-size packet holds the header plus this many extra words. 0x02 takes 2. 0x20–23 take 3, 0x24–27 take 6, 0x28–2B take 4, 0x2C–2F take 8, 0x30–33 take 5, 0x34–37 take 8, 0x38–3B take 7 and 0x3C–3F take 11. 0x40–47 take 2 and 0x50–57 take 3. Among 0x60–7F, each group of four opcodes takes in turn 2,3,1,2,1,2,1,2 words. 0x80 takes 3.
- R2: The cycle after the edge that accepts a packet's last word, `pkt_valid` is high for exactly one cycle. In that cycle `pkt_opcode` holds the opcode, `pkt_len` holds the total number of words including the header, and word k of the packet is on `pkt_words[32k+31:32k]`.
- R3: A flat line strip (0x48–4F) ends on the first word at index 3 or higher for which (word & 0xF000F000) == 0x50005000. Index 0 is the header. The marker word is part of the packet. A word that matches at index 1 or 2 does not end the packet.
- R4: A shaded line strip (0x58–5F) uses the same marker test, but only on even indexes of 4 or higher. A matching word at an odd index, or at an index below 4, does not end the packet.
- R5: A line strip with no marker is closed once it holds MAX_WORDS words, with `pkt_len` = MAX_WORDS. The next word is then taken as a new header.
- R6: An opcode in 0xE0–E7 writes the whole word into environment register (opcode & 7), which is seen on `env_regs[32i+31:32i]`. The other registers keep their values and no strobe is produced.
- R7: After every environment write, `status[10:0]` equals register 1 bits 10:0 and `status[12:11]` equals register 6 bits 1:0.
- R8: After reset, environment register i holds (0xE0+i)<<24, `status` is 0, both strobes are low and `in_ready` is high.
- R9: An opcode in 0xA0–DF takes two parameter words and produces a one-cycle `xfer_valid` with `xfer_pos` (first word) and `xfer_size` (second word), and no `pkt_valid`. `xfer_read` is 1 for 0xC0–DF and 0 for 0xA0–BF.
- R10: A packet whose words have not all arrived produces no strobe. Cycles with `in_valid` low are ignored, and the packet completes when its last word arrives.
- R11: Any other opcode is taken as a one-word no-op. It produces no strobe and does not change the environment registers, and the next word is a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input command word |
| in_ready | output | 1 | Always high; a word is taken on every valid cycle |
| pkt_valid | output | 1 | Drawing packet complete strobe |
| pkt_opcode | output | 8 | Opcode of the completed packet |
| pkt_len | output | LEN_W | Total words in the packet, header included |
| pkt_words | output | 32*MAX_WORDS | Packet words, word k in bits 32k+31:32k |
| xfer_valid | output | 1 | Rectangle-transfer request strobe |
| xfer_read | output | 1 | 1 = memory to host, 0 = host to memory |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| env_regs | output | 256 | Eight environment registers, register i in bits 32i+31:32i |
| status | output | 13 | Status bits rebuilt from registers 1 and 6 |

## Verification
The hardest cases to reach are line strips that contain marker-shaped words the framer must skip. These are words below the first checked index, and for shaded strips, words at odd indexes. A strip with no marker at all must also end exactly at the length cap. The stimulus builds strips word by word and places marker patterns at these indexes on purpose. After the capped strip it sends a short fixed packet to show that framing has recovered. Pauses in `in_valid` are inserted in the middle of a packet to show that a partial packet stays pending.

// File: rtl/gcf_pkg.sv
package gcf_pkg;

    localparam int unsigned EXTRA_W = 4;
    localparam int unsigned N_ENV   = 8;
    localparam int unsigned STAT_W  = 13;

    localparam logic [31:0] TERM_MASK = 32'hF000_F000;
    localparam logic [31:0] TERM_VAL  = 32'h5000_5000;

    typedef enum logic [2:0] {
        K_NOP   = 3'd0,
        K_FIX   = 3'd1,
        K_FLAT  = 3'd2,
        K_SHADE = 3'd3,
        K_XFER  = 3'd4,
        K_ENV   = 3'd5
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic [EXTRA_W-1:0] extra;
    } dec_t;

endpackage

// File: rtl/gcf_opdec.sv
module gcf_opdec
    import gcf_pkg::*;
(
    input  logic [7:0] op_i,
    output dec_t       dec_o
);

    always_comb begin
        dec_o.kind  = K_NOP;
        dec_o.extra = '0;
        if (op_i == 8'h02) begin
            dec_o.kind  = K_FIX;
            dec_o.extra = 4'd2;
        end else if (op_i[7:5] == 3'b001) begin
            // polygons: length chosen by groups of four opcodes
            dec_o.kind = K_FIX;
            case (op_i[4:2])
                3'd0:    dec_o.extra = 4'd3;
                3'd1:    dec_o.extra = 4'd6;
                3'd2:    dec_o.extra = 4'd4;
                3'd3:    dec_o.extra = 4'd8;
                3'd4:    dec_o.extra = 4'd5;
                3'd5:    dec_o.extra = 4'd8;
                3'd6:    dec_o.extra = 4'd7;
                default: dec_o.extra = 4'd11;
            endcase
        end else if (op_i[7:4] == 4'h4) begin
            if (op_i[3]) begin
                dec_o.kind = K_FLAT;
            end else begin
                dec_o.kind  = K_FIX;
                dec_o.extra = 4'd2;
            end
        end else if (op_i[7:4] == 4'h5) begin
            if (op_i[3]) begin
                dec_o.kind = K_SHADE;
            end else begin
                dec_o.kind  = K_FIX;
                dec_o.extra = 4'd3;
            end
        end else if (op_i[7:5] == 3'b011) begin
            // sprites: variable size first, then fixed sizes
            dec_o.kind = K_FIX;
            case (op_i[4:2])
                3'd0:    dec_o.extra = 4'd2;
                3'd1:    dec_o.extra = 4'd3;
                3'd2:    dec_o.extra = 4'd1;
                3'd3:    dec_o.extra = 4'd2;
                3'd4:    dec_o.extra = 4'd1;
                3'd5:    dec_o.extra = 4'd2;
                3'd6:    dec_o.extra = 4'd1;
                default: dec_o.extra = 4'd2;
            endcase
        end else if (op_i == 8'h80) begin
            dec_o.kind  = K_FIX;
            dec_o.extra = 4'd3;
        end else if ((op_i[7:5] == 3'b101) || (op_i[7:5] == 3'b110)) begin
            dec_o.kind  = K_XFER;
            dec_o.extra = 4'd2;
        end else if (op_i[7:3] == 5'b11100) begin
            dec_o.kind = K_ENV;
        end
    end

endmodule

// File: rtl/gcf_polyterm.sv
module gcf_polyterm
    import gcf_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  kind_e            kind_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [31:0]      word_i,
    output logic             hit_o
);

    logic pattern;

    always_comb begin
        pattern = ((word_i & TERM_MASK) == TERM_VAL);
        hit_o   = 1'b0;
        if (kind_i == K_FLAT) begin
            hit_o = pattern && (idx_i >= IDX_W'(3));
        end else if (kind_i == K_SHADE) begin
            hit_o = pattern && (idx_i >= IDX_W'(4)) && !idx_i[0];
        end
    end

endmodule

// File: rtl/gcf_envfile.sv
module gcf_envfile
    import gcf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [2:0]            idx_i,
    input  logic [31:0]           wdata_i,
    output logic [N_ENV*32-1:0]   env_o,
    output logic [STAT_W-1:0]     status_o
);

    typedef struct packed {
        logic [N_ENV-1:0][31:0] env;
        logic [STAT_W-1:0]      status;
    } env_st_t;

    function automatic env_st_t reset_state();
        env_st_t s;
        s.status = '0;
        for (int i = 0; i < int'(N_ENV); i++) begin
            s.env[i] = (32'hE0 + 32'(i)) << 24;
        end
        return s;
    endfunction

    env_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.env[idx_i] = wdata_i;
            st_d.status     = {st_d.env[6][1:0], st_d.env[1][10:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end

    assign env_o    = st_q.env;
    assign status_o = st_q.status;

    a_r7_status_low: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && idx_i == 3'd1) |=> (status_o[10:0] == $past(wdata_i[10:0])));

    a_r7_status_high: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && idx_i == 3'd6) |=> (status_o[12:11] == $past(wdata_i[1:0])));

    for (genvar k = 0; k < int'(N_ENV); k++) begin : g_keep
        a_r6_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (!(we_i && idx_i == 3'(k))) |=> $stable(env_o[k*32 +: 32]));
    end

endmodule

// File: rtl/gcf_framer.sv
module gcf_framer
    import gcf_pkg::*;
#(
    parameter int unsigned MAX_WORDS = 16,
    localparam int unsigned LEN_W = $clog2(MAX_WORDS + 1),
    localparam int unsigned IDX_W = $clog2(MAX_WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [31:0]            in_data,
    output logic                   in_ready,
    output logic                   pkt_valid,
    output logic [7:0]             pkt_opcode,
    output logic [LEN_W-1:0]       pkt_len,
    output logic [32*MAX_WORDS-1:0] pkt_words,
    output logic                   xfer_valid,
    output logic                   xfer_read,
    output logic [31:0]            xfer_pos,
    output logic [31:0]            xfer_size,
    output logic [N_ENV*32-1:0]    env_regs,
    output logic [STAT_W-1:0]      status
);
    // MAX_WORDS must be at least 12 so the longest fixed packet fits.

    typedef struct packed {
        logic                       busy;
        kind_e                      kind;
        logic [7:0]                 op;
        logic [LEN_W-1:0]           need;
        logic [LEN_W-1:0]           cnt;
        logic [MAX_WORDS-1:0][31:0] words;
        logic [31:0]                last;
        logic                       pkt_v;
        logic [LEN_W-1:0]           pkt_len;
        logic                       xf_v;
        logic                       xf_rd;
        logic [31:0]                xf_pos;
        logic [31:0]                xf_size;
    } fr_st_t;

    fr_st_t q, d;
    dec_t   hdr_dec;
    logic   term_hit;
    logic   env_we;
    logic   done;
    logic [LEN_W-1:0] cnt_inc;

    gcf_opdec u_dec (
        .op_i  (in_data[31:24]),
        .dec_o (hdr_dec)
    );

    gcf_polyterm #(.IDX_W(LEN_W)) u_term (
        .kind_i (q.kind),
        .idx_i  (q.cnt),
        .word_i (in_data),
        .hit_o  (term_hit)
    );

    gcf_envfile u_env (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (env_we),
        .idx_i    (in_data[26:24]),
        .wdata_i  (in_data),
        .env_o    (env_regs),
        .status_o (status)
    );

    always_comb begin
        d       = q;
        d.pkt_v = 1'b0;
        d.xf_v  = 1'b0;
        env_we  = 1'b0;
        done    = 1'b0;
        cnt_inc = q.cnt + LEN_W'(1);
        if (in_valid) begin
            d.last = in_data;
            if (!q.busy) begin
                case (hdr_dec.kind)
                    K_NOP: ;
                    K_ENV: env_we = 1'b1;
                    default: begin
                        d.busy     = 1'b1;
                        d.kind     = hdr_dec.kind;
                        d.op       = in_data[31:24];
                        d.need     = LEN_W'(hdr_dec.extra) + LEN_W'(1);
                        d.cnt      = LEN_W'(1);
                        d.words[0] = in_data;
                    end
                endcase
            end else begin
                d.words[q.cnt[IDX_W-1:0]] = in_data;
                d.cnt = cnt_inc;
                if ((q.kind == K_FLAT) || (q.kind == K_SHADE)) begin
                    done = term_hit || (cnt_inc == LEN_W'(MAX_WORDS));
                end else begin
                    done = (cnt_inc == q.need);
                end
                if (done) begin
                    d.busy = 1'b0;
                    if (q.kind == K_XFER) begin
                        d.xf_v    = 1'b1;
                        d.xf_rd   = (q.op[7:5] == 3'b110);
                        d.xf_pos  = q.words[1];
                        d.xf_size = in_data;
                    end else begin
                        d.pkt_v   = 1'b1;
                        d.pkt_len = cnt_inc;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= fr_st_t'(0);
        else        q <= d;
    end

    assign in_ready   = 1'b1;
    assign pkt_valid  = q.pkt_v;
    assign pkt_opcode = q.op;
    assign pkt_len    = q.pkt_len;
    assign pkt_words  = q.words;
    assign xfer_valid = q.xf_v;
    assign xfer_read  = q.xf_rd;
    assign xfer_pos   = q.xf_pos;
    assign xfer_size  = q.xf_size;

    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pkt_valid, xfer_valid}));

    a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len >= LEN_W'(2)) && (pkt_len <= LEN_W'(MAX_WORDS)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(pkt_valid || xfer_valid));

    a_r3_flat_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_opcode[7:3] == 5'b01001 && pkt_len != LEN_W'(MAX_WORDS))
        |-> ((q.last & TERM_MASK) == TERM_VAL));

    a_r4_shade_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_opcode[7:3] == 5'b01011 && pkt_len != LEN_W'(MAX_WORDS))
        |-> (((q.last & TERM_MASK) == TERM_VAL) && pkt_len[0]));

    a_r9_xfer_group: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (pkt_opcode[7:5] == 3'b101 || pkt_opcode[7:5] == 3'b110));

endmodule

// File: tb/sim_gcf_framer.sv
module sim_gcf_framer;
    localparam int MAXW  = 16;
    localparam int LENW  = $clog2(MAXW + 1);
    localparam logic [31:0] MARK = 32'h5A0A_5B0B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic in_ready, pkt_valid, xfer_valid, xfer_read;
    logic [7:0] pkt_opcode;
    logic [LENW-1:0] pkt_len;
    logic [32*MAXW-1:0] pkt_words;
    logic [31:0] xfer_pos, xfer_size;
    logic [255:0] env_regs;
    logic [12:0] status;

    int n_chk = 0;
    int n_bad = 0;
    int pkt_seen = 0;
    int xf_seen = 0;
    logic [7:0] m_op;
    logic [LENW-1:0] m_len;
    logic [32*MAXW-1:0] m_words;
    logic m_rd;
    logic [31:0] m_pos, m_size;

    always #4 clk = ~clk;

    gcf_framer #(.MAX_WORDS(MAXW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_opcode(pkt_opcode),
        .pkt_len(pkt_len), .pkt_words(pkt_words), .xfer_valid(xfer_valid),
        .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .env_regs(env_regs), .status(status)
    );

    always @(negedge clk) begin
        if (pkt_valid) begin
            pkt_seen++;
            m_op = pkt_opcode; m_len = pkt_len; m_words = pkt_words;
        end
        if (xfer_valid) begin
            xf_seen++;
            m_rd = xfer_read; m_pos = xfer_pos; m_size = xfer_size;
        end
    end

    // stimulus table: opcode, expected total words (R1)
    localparam int NV = 19;
    localparam logic [12:0] VEC [NV] = '{
        {8'h02, 5'd3},  {8'h20, 5'd4},  {8'h25, 5'd7},  {8'h2A, 5'd5},
        {8'h2F, 5'd9},  {8'h31, 5'd6},  {8'h36, 5'd9},  {8'h3A, 5'd8},
        {8'h3F, 5'd12}, {8'h44, 5'd3},  {8'h52, 5'd4},  {8'h60, 5'd3},
        {8'h65, 5'd4},  {8'h6A, 5'd2},  {8'h6D, 5'd3},  {8'h76, 5'd3},
        {8'h78, 5'd2},  {8'h7D, 5'd3},  {8'h80, 5'd4}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_fix(input logic [7:0] op, input int tot);
        int base;
        base = pkt_seen;
        put({op, 16'h0, 8'(tot)});
        for (int k = 1; k < tot; k++) put(32'h0A00_0000 | 32'(k));
        idle(2);
        chk("R2 strobe count", 64'(pkt_seen - base), 64'd1);
        chk("R2 opcode", 64'(m_op), 64'(op));
        chk("R1 length", 64'(m_len), 64'(tot));
        chk("R2 header word", 64'(m_words[31:0]), 64'({op, 16'h0, 8'(tot)}));
        chk("R2 last word", 64'(m_words[(tot-1)*32 +: 32]), 64'(32'h0A00_0000 | 32'(tot-1)));
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int base, xbase;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        for (int i = 0; i < 8; i++)
            chk("R8 env reset", 64'(env_regs[i*32 +: 32]), 64'((32'hE0 + 32'(i)) << 24));
        chk("R8 status reset", 64'(status), 64'd0);
        chk("R8 strobes low", 64'({pkt_valid, xfer_valid}), 64'd0);
        chk("R8 ready high", 64'(in_ready), 64'd1);

        // R1 / R2 table walk
        for (int v = 0; v < NV; v++) send_fix(VEC[v][12:5], int'(VEC[v][4:0]));

        // R3 flat strip, marker at index 3
        base = pkt_seen;
        put(32'h4800_0000); put(32'h0A00_0001); put(32'h0A00_0002); put(MARK);
        idle(2);
        chk("R3 strobe", 64'(pkt_seen - base), 64'd1);
        chk("R3 length", 64'(m_len), 64'd4);
        chk("R3 marker word", 64'(m_words[3*32 +: 32]), 64'(MARK));

        // R3 marker at index 2 ignored, ends at index 5
        base = pkt_seen;
        put(32'h4A00_0000); put(32'h0A00_0001); put(MARK); put(32'h0A00_0003);
        put(32'h0A00_0004); put(MARK);
        idle(2);
        chk("R3 early marker ignored", 64'(pkt_seen - base), 64'd1);
        chk("R3 length late", 64'(m_len), 64'd6);

        // R4 shaded: markers at 2,3,5 ignored, ends at 6
        base = pkt_seen;
        put(32'h5C00_0000); put(32'h0A00_0001); put(MARK); put(MARK);
        put(32'h0A00_0004); put(MARK); put(MARK);
        idle(2);
        chk("R4 strobe", 64'(pkt_seen - base), 64'd1);
        chk("R4 length", 64'(m_len), 64'd7);
        chk("R4 opcode", 64'(m_op), 64'h5C);

        // R5 cap without marker
        base = pkt_seen;
        put(32'h4900_0000);
        for (int k = 1; k < MAXW; k++) put(32'h0A00_0000 | 32'(k));
        idle(2);
        chk("R5 cap strobe", 64'(pkt_seen - base), 64'd1);
        chk("R5 cap length", 64'(m_len), 64'(MAXW));
        send_fix(8'h02, 3); // R5 framing recovered

        // R10 partial packet pending
        base = pkt_seen;
        put(32'h2800_0000); put(32'h0A00_0001); put(32'h0A00_0002);
        idle(6);
        chk("R10 no strobe while partial", 64'(pkt_seen - base), 64'd0);
        put(32'h0A00_0003); put(32'h0A00_0004);
        idle(2);
        chk("R10 completes", 64'(pkt_seen - base), 64'd1);
        chk("R10 length", 64'(m_len), 64'd5);
        chk("R10 word 4", 64'(m_words[4*32 +: 32]), 64'h0A00_0004);

        // R6 / R7 environment writes
        base = pkt_seen; xbase = xf_seen;
        put(32'hE100_0DA5);
        idle(2);
        chk("R6 env1 written", 64'(env_regs[32 +: 32]), 64'hE100_0DA5);
        chk("R6 env0 kept", 64'(env_regs[0 +: 32]), 64'hE000_0000);
        chk("R6 env7 kept", 64'(env_regs[7*32 +: 32]), 64'hE700_0000);
        chk("R7 status low", 64'(status), 64'h05A5);
        put(32'hE600_0003);
        idle(2);
        chk("R6 env6 written", 64'(env_regs[6*32 +: 32]), 64'hE600_0003);
        chk("R7 status high", 64'(status), 64'h1DA5);
        chk("R6 no strobe", 64'((pkt_seen - base) + (xf_seen - xbase)), 64'd0);

        // R9 transfers
        base = pkt_seen; xbase = xf_seen;
        put(32'hA500_0000); put(32'h0010_0020); put(32'h0008_0010);
        idle(2);
        chk("R9 write strobe", 64'(xf_seen - xbase), 64'd1);
        chk("R9 write dir", 64'(m_rd), 64'd0);
        chk("R9 pos", 64'(m_pos), 64'h0010_0020);
        chk("R9 size", 64'(m_size), 64'h0008_0010);
        put(32'hC700_0000); put(32'h0003_0004); put(32'h0001_0002);
        idle(2);
        chk("R9 read strobe", 64'(xf_seen - xbase), 64'd2);
        chk("R9 read dir", 64'(m_rd), 64'd1);
        chk("R9 no packet", 64'(pkt_seen - base), 64'd0);

        // R11 no-ops
        base = pkt_seen; xbase = xf_seen;
        put(32'h0100_0000); put(32'hF500_0000); put(32'h0000_0000);
        idle(2);
        chk("R11 no strobe", 64'((pkt_seen - base) + (xf_seen - xbase)), 64'd0);
        chk("R11 env unchanged", 64'(env_regs[5*32 +: 32]), 64'hE500_0000);
        send_fix(8'h44, 3); // R11 next word is a header

        summary();
        $finish;
    end

endmodule